// File: doc/BRIEF.md
# Paddle Game Session Controller

This block sequences one single-player session of a paddle-and-ball game. It starts in a new-game state with the rules overlay selected. It waits for a player button, then lets the ball engine run. Hit pulses from the ball engine add to a decimal score. Each miss uses up one ball from a fixed budget and pauses the game until a frame-tick timer has run out and a button is pressed again. A miss with no ball left selects the game-over overlay. That overlay holds until the timer expires, and then the block returns to the new-game state.

The two-digit BCD score counter and the pause timer are inside the block. The freeze output tells the graphics to hold the ball and paddle still. The two overlay flags select which message the text renderer draws. The remaining-ball count and the score digits feed the on-screen status line.

Top module: `paddle_session_ctrl`

## Requirements
- R1: After reset the block is in the new-game state. `show_rules`=1, `freeze`=1, `show_over`=0, `score_bcd`=8'h00, `balls_left`=3 and `pause_done`=1 (the timer rests at zero).
- R2: In the new-game state, an edge with any `btn` bit high enters play at that edge: `freeze`=0, `show_rules`=0, `balls_left`=2.
- R3: During play, each `hit` pulse adds one to the score at that edge. The ones digit (bits 3:0) goes from 9 to 0 and carries into the tens digit (bits 7:4).
- R4: A hit while the score reads 99 makes it read 00.
- R5: `hit` and `miss` have no effect outside play. The score, ball count and overlay flags stay unchanged.
- R6: A miss during play with `balls_left` nonzero enters the pause state: `freeze`=1, `balls_left` drops by one, and the timer loads all ones (`pause_done`=0).
- R7: The 7-bit timer counts down by one only at edges where `frame_tick`=1. `pause_done` goes high at the edge of the 127th tick after the load and stays high.
- R8: In the pause state, play resumes only at an edge where `pause_done`=1 and a button is high. A button pressed earlier, or an expired timer with no button, leaves `freeze`=1.
- R9: A miss during play with `balls_left`=0 enters the game-over state: `show_over`=1, `freeze`=1, and the timer loads (`pause_done`=0).
- R10: In the game-over state, the edge after the timer has expired returns to the new-game state whatever the buttons are. At that edge `show_rules`=1, `show_over`=0, `score_bcd`=8'h00 and `balls_left`=3.
- R11: `freeze` is low exactly in play, and at most one of `show_rules`, `show_over`, `!freeze` is high.
- R12: Each edge moves at most one state. A button held through the end of the game-over state first reaches the new-game state, and only at the following edge enters play.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | BTN_W (2) | Debounced player buttons, any high bit counts as a press |
| hit | input | 1 | One-cycle pulse: the paddle struck the ball |
| miss | input | 1 | One-cycle pulse: the ball passed the paddle |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| freeze | output | 1 | Hold the graphics still (high outside play) |
| show_rules | output | 1 | Select the rules overlay |
| show_over | output | 1 | Select the game-over overlay |
| balls_left | output | BALL_W (2) | Balls remaining in the session |
| score_bcd | output | 4*SCORE_DIGITS (8) | BCD score, ones digit in bits 3:0 |
| pause_done | output | 1 | Pause timer has reached zero |

## Verification
The hardest situations to reach are the score wrap from 99 and the end of the game-over state with a button still held. Both sit deep in a long session. The stimulus first plays one ball for a hundred hits so that the score passes through 09, 10 and 99 and wraps. It then spends the remaining balls with full 127-tick pauses. During the last game-over pause it keeps both buttons high, so that the single-step move back to new game and then into play can be observed edge by edge.

// File: rtl/paddle_session_pkg.sv
package paddle_session_pkg;
  typedef enum logic [1:0] {
    ST_NEWGAME = 2'd0,
    ST_PLAY    = 2'd1,
    ST_PAUSE   = 2'd2,
    ST_OVER    = 2'd3
  } sess_state_t;
endpackage

// File: rtl/bcd_score_counter.sv
module bcd_score_counter #(
  parameter int NUM_DIGITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    inc,
  output logic [NUM_DIGITS*4-1:0] digits
);
  logic [NUM_DIGITS:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic [3:0] dig_q;
    assign carry[i+1] = carry[i] && (dig_q == 4'd9);
    assign digits[i*4 +: 4] = dig_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        dig_q <= 4'd0;
      end else if (carry[i]) begin
        dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
      end
    end
  end
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int WIDTH = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic done
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/session_fsm.sv
module session_fsm
  import paddle_session_pkg::*;
#(
  parameter int BALLS  = 3,
  parameter int BALL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn_any,
  input  logic              hit,
  input  logic              miss,
  input  logic              timer_done,
  output logic              score_inc,
  output logic              score_clr,
  output logic              timer_start,
  output logic              freeze_q,
  output logic              rules_q,
  output logic              over_q,
  output logic [BALL_W-1:0] balls_q
);
  localparam logic [BALL_W-1:0] BALLS_FULL = BALL_W'(BALLS);

  sess_state_t       state_q, state_d;
  logic [BALL_W-1:0] balls_d;

  always_comb begin
    state_d     = state_q;
    balls_d     = balls_q;
    score_inc   = 1'b0;
    timer_start = 1'b0;
    unique case (state_q)
      ST_NEWGAME: begin
        if (btn_any) begin
          state_d = ST_PLAY;
          balls_d = BALLS_FULL - 1'b1;
        end
      end
      ST_PLAY: begin
        score_inc = hit;
        if (miss) begin
          timer_start = 1'b1;
          if (balls_q == '0) begin
            state_d = ST_OVER;
          end else begin
            state_d = ST_PAUSE;
            balls_d = balls_q - 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        if (timer_done && btn_any) state_d = ST_PLAY;
      end
      ST_OVER: begin
        if (timer_done) state_d = ST_NEWGAME;
      end
      default: state_d = ST_NEWGAME;
    endcase
    if (state_d == ST_NEWGAME) balls_d = BALLS_FULL;
  end

  assign score_clr = (state_d == ST_NEWGAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_NEWGAME;
      balls_q  <= BALLS_FULL;
      freeze_q <= 1'b1;
      rules_q  <= 1'b1;
      over_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      balls_q  <= balls_d;
      freeze_q <= (state_d != ST_PLAY);
      rules_q  <= (state_d == ST_NEWGAME);
      over_q   <= (state_d == ST_OVER);
    end
  end
endmodule

// File: rtl/paddle_session_ctrl.sv
module paddle_session_ctrl #(
  parameter int BTN_W        = 2,
  parameter int BALLS        = 3,
  parameter int SCORE_DIGITS = 2,
  parameter int TIMER_W      = 7,
  localparam int BALL_W      = $clog2(BALLS + 1),
  localparam int SCORE_W     = SCORE_DIGITS * 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BTN_W-1:0]   btn,
  input  logic               hit,
  input  logic               miss,
  input  logic               frame_tick,
  output logic               freeze,
  output logic               show_rules,
  output logic               show_over,
  output logic [BALL_W-1:0]  balls_left,
  output logic [SCORE_W-1:0] score_bcd,
  output logic               pause_done
);
  logic score_inc, score_clr, timer_start;

  session_fsm #(
    .BALLS  (BALLS),
    .BALL_W (BALL_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .btn_any     (|btn),
    .hit         (hit),
    .miss        (miss),
    .timer_done  (pause_done),
    .score_inc   (score_inc),
    .score_clr   (score_clr),
    .timer_start (timer_start),
    .freeze_q    (freeze),
    .rules_q     (show_rules),
    .over_q      (show_over),
    .balls_q     (balls_left)
  );

  bcd_score_counter #(
    .NUM_DIGITS (SCORE_DIGITS)
  ) u_score (
    .clk    (clk),
    .rst    (rst),
    .clr    (score_clr),
    .inc    (score_inc),
    .digits (score_bcd)
  );

  pause_timer #(
    .WIDTH (TIMER_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (timer_start),
    .tick  (frame_tick),
    .done  (pause_done)
  );
endmodule

// File: rtl/paddle_session_checker.sv
module paddle_session_checker #(
  parameter int BALL_W  = 2,
  parameter int SCORE_W = 8,
  parameter int BALLS   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               hit,
  input logic               miss,
  input logic               freeze,
  input logic               show_rules,
  input logic               show_over,
  input logic [BALL_W-1:0]  balls_left,
  input logic [SCORE_W-1:0] score_bcd,
  input logic               pause_done
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (show_rules && freeze && !show_over && score_bcd == '0
                    && balls_left == BALL_W'(BALLS)));

  p_ones_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!freeze && hit && score_bcd[3:0] != 4'd9)
      |=> (score_bcd[3:0] == $past(score_bcd[3:0]) + 4'd1));

  p_wrap_99_r4: assert property (@(posedge clk) disable iff (rst)
    (!freeze && hit && score_bcd == SCORE_W'(8'h99)) |=> (score_bcd == '0));

  p_frozen_score_r5: assert property (@(posedge clk) disable iff (rst)
    (freeze && !show_over) |=> $stable(score_bcd));

  p_miss_pause_r6: assert property (@(posedge clk) disable iff (rst)
    (!freeze && miss && balls_left != '0)
      |=> (freeze && !show_over && !pause_done
           && balls_left == $past(balls_left) - 1'b1));

  p_hold_pause_r8: assert property (@(posedge clk) disable iff (rst)
    (freeze && !show_rules && !show_over && !pause_done) |=> freeze);

  p_last_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (!freeze && miss && balls_left == '0) |=> (show_over && freeze && !pause_done));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({show_rules, show_over, !freeze}));

  p_no_skip_r12: assert property (@(posedge clk) disable iff (rst)
    show_over |=> (show_over || show_rules));
endmodule

bind paddle_session_ctrl paddle_session_checker #(
  .BALL_W  (BALL_W),
  .SCORE_W (SCORE_W),
  .BALLS   (BALLS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hit        (hit),
  .miss       (miss),
  .freeze     (freeze),
  .show_rules (show_rules),
  .show_over  (show_over),
  .balls_left (balls_left),
  .score_bcd  (score_bcd),
  .pause_done (pause_done)
);

// File: tb/paddle_session_ctrl_bench.sv
module paddle_session_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] btn = 2'b00;
  logic       hit = 1'b0;
  logic       miss = 1'b0;
  logic       frame_tick = 1'b0;
  logic       freeze, show_rules, show_over, pause_done;
  logic [1:0] balls_left;
  logic [7:0] score_bcd;

  int checks = 0;
  int errors = 0;
  int exp_score = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  paddle_session_ctrl u_paddle_session_ctrl (
    .clk        (clk),
    .rst        (rst),
    .btn        (btn),
    .hit        (hit),
    .miss       (miss),
    .frame_tick (frame_tick),
    .freeze     (freeze),
    .show_rules (show_rules),
    .show_over  (show_over),
    .balls_left (balls_left),
    .score_bcd  (score_bcd),
    .pause_done (pause_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_bcd(input int s);
    return ((s / 10) << 4) | (s % 10);
  endfunction

  task automatic step(input logic [1:0] b, input logic h, input logic m, input logic t);
    @(negedge clk);
    btn = b; hit = h; miss = m; frame_tick = t;
    @(posedge clk);
    #1;
    @(negedge clk);
    btn = 2'b00; hit = 1'b0; miss = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic step_hold(input logic [1:0] b, input logic t);
    @(negedge clk);
    btn = b; frame_tick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rules", int'(show_rules), 1);
    chk("R1 freeze", int'(freeze), 1);
    chk("R1 over", int'(show_over), 0);
    chk("R1 score", int'(score_bcd), 0);
    chk("R1 balls", int'(balls_left), 3);
    chk("R1 pause_done", int'(pause_done), 1);
  endtask

  task automatic t_idle_ignore;
    step(2'b00, 1'b1, 1'b0, 1'b0);
    step(2'b00, 1'b0, 1'b1, 1'b0);
    chk("R5 idle rules", int'(show_rules), 1);
    chk("R5 idle score", int'(score_bcd), 0);
    chk("R5 idle balls", int'(balls_left), 3);
  endtask

  task automatic t_start;
    step(2'b10, 1'b0, 1'b0, 1'b0);
    chk("R2 freeze", int'(freeze), 0);
    chk("R2 rules", int'(show_rules), 0);
    chk("R2 balls", int'(balls_left), 2);
    chk("R11 over in play", int'(show_over), 0);
  endtask

  task automatic t_score;
    for (int i = 0; i < 100; i++) begin
      step(2'b00, 1'b1, 1'b0, 1'b0);
      exp_score = (exp_score + 1) % 100;
      if (exp_score == 9 || exp_score == 10)
        chk("R3 carry", int'(score_bcd), to_bcd(exp_score));
      if (exp_score == 99)
        chk("R3 reach 99", int'(score_bcd), 8'h99);
    end
    chk("R4 wrap", int'(score_bcd), 0);
    for (int i = 0; i < 3; i++) step(2'b00, 1'b1, 1'b0, 1'b0);
    exp_score = 3;
    chk("R3 count", int'(score_bcd), to_bcd(exp_score));
  endtask

  task automatic t_pause_detail;
    step(2'b00, 1'b0, 1'b1, 1'b0);
    chk("R6 freeze", int'(freeze), 1);
    chk("R6 balls", int'(balls_left), 1);
    chk("R6 timer loaded", int'(pause_done), 0);
    step(2'b00, 1'b1, 1'b0, 1'b0);
    chk("R5 hit in pause", int'(score_bcd), to_bcd(exp_score));
    step(2'b01, 1'b0, 1'b0, 1'b0);
    chk("R8 early button", int'(freeze), 1);
    for (int i = 0; i < 126; i++) step(2'b00, 1'b0, 1'b0, 1'b1);
    chk("R7 126 ticks", int'(pause_done), 0);
    step(2'b00, 1'b0, 1'b0, 1'b0);
    chk("R7 no tick", int'(pause_done), 0);
    step(2'b00, 1'b0, 1'b0, 1'b1);
    chk("R7 expired", int'(pause_done), 1);
    step(2'b00, 1'b0, 1'b0, 1'b1);
    chk("R7 holds zero", int'(pause_done), 1);
    chk("R8 no button", int'(freeze), 1);
    step(2'b01, 1'b0, 1'b0, 1'b0);
    chk("R8 resume", int'(freeze), 0);
  endtask

  task automatic t_second_ball;
    step(2'b00, 1'b0, 1'b1, 1'b0);
    chk("R6 second miss balls", int'(balls_left), 0);
    for (int i = 0; i < 127; i++) step(2'b00, 1'b0, 1'b0, 1'b1);
    step(2'b11, 1'b0, 1'b0, 1'b0);
    chk("R8 resume last ball", int'(freeze), 0);
  endtask

  task automatic t_game_over;
    step(2'b00, 1'b0, 1'b1, 1'b0);
    chk("R9 over", int'(show_over), 1);
    chk("R9 freeze", int'(freeze), 1);
    chk("R9 balls", int'(balls_left), 0);
    chk("R9 timer loaded", int'(pause_done), 0);
    for (int i = 0; i < 127; i++) step_hold(2'b11, 1'b1);
    chk("R10 still over at expiry", int'(show_over), 1);
    step_hold(2'b11, 1'b0);
    chk("R10 rules", int'(show_rules), 1);
    chk("R10 over cleared", int'(show_over), 0);
    chk("R10 score", int'(score_bcd), 0);
    chk("R10 balls", int'(balls_left), 3);
    chk("R12 no skip", int'(freeze), 1);
    step_hold(2'b11, 1'b0);
    chk("R12 play after", int'(freeze), 0);
    chk("R12 balls", int'(balls_left), 2);
    @(negedge clk);
    btn = 2'b00;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_start();
    t_score();
    t_pause_detail();
    t_second_ball();
    t_game_over();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule